// File: doc/BRIEF.md
# Split-Transaction Outstanding Request Tracker

This block keeps the table of memory transactions that are still in flight on a pipelined split-transaction bus. Requests and responses use separate buses. When a request on the request bus is accepted, it is given a tag and stored in a table entry. The tag is the entry's index. Memory answers later on the response bus with the same tag, and that answer frees the entry. Responses may come back in any order. A request is refused with a NACK in two cases: its cache-line address matches an entry that is still pending, or no entry is free.

Every processor's cache controller holds one instance of this block. All instances watch the same two buses and apply the same rules, so they stay identical without any extra messages. The tag space is global. This means at most `ENTRIES` transactions (eight by default, three tag bits) are outstanding across the whole system. The accept/NACK decision and the chosen tag are computed combinationally from the table as it stands in the current cycle. Table updates take effect at the next clock edge.

Top module: `rt_table`

## Requirements
- R1: After reset, every entry is free, `tbl_full` and `proto_err` are 0, and with no request present `req_ack` and `req_nack` are 0.
- R2: A request with `req_valid`=1 that has no conflict while a free entry exists gets `req_ack`=1 in the same cycle. `req_tag` is the lowest-numbered free entry, and that entry is pending from the next cycle on. When `req_ack` is 0, `req_tag` reads 0.
- R3: A request whose `req_line` equals the line stored in any pending entry gets `req_nack`=1 and `req_ack`=0, and no entry is allocated.
- R4: `tbl_full` is 1 exactly when all entries are pending. While it is 1, every request gets `req_nack`=1.
- R5: A response (`rsp_valid`=1) whose `rsp_tag` names a pending entry frees that entry at the next clock edge, whatever order the requests were made in.
- R6: An entry freed by a response in a cycle is still treated as pending for requests in that same cycle. It can be neither allocated nor bypassed for the conflict check until the next cycle.
- R7: A response whose tag names a free entry leaves the table unchanged and sets `proto_err` from the next cycle. `proto_err` then stays 1 until reset.
- R8: During a response to a pending entry, `rsp_line`, `rsp_pid` and `rsp_cmd` show the line, processor ID and command (0 = read, 1 = read-exclusive) stored when that entry was allocated. Otherwise these outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is on the request bus this cycle |
| req_line | input | LINE_W | Cache-line address of the request (byte address without line offset) |
| req_pid | input | PID_W | Requesting processor ID |
| req_cmd | input | 1 | 0 = read, 1 = read-exclusive |
| rsp_valid | input | 1 | A response is on the response bus this cycle |
| rsp_tag | input | TAG_W | Tag the response answers |
| req_ack | output | 1 | Request accepted and allocated |
| req_nack | output | 1 | Request refused (conflict or table full) |
| req_tag | output | TAG_W | Tag given to the accepted request |
| tbl_full | output | 1 | All entries pending |
| rsp_line | output | LINE_W | Stored line of the entry being answered |
| rsp_pid | output | PID_W | Stored processor ID of the entry being answered |
| rsp_cmd | output | 1 | Stored command of the entry being answered |
| proto_err | output | 1 | Sticky flag: a response named a free tag |

## Verification
Directed sequences are used first:
- Distinct lines are allocated, which separates lowest-free tag selection from any other order.
- A line is reissued while it is pending, and the table is filled to capacity; these separate the conflict NACK from the full NACK.
- Out-of-order responses are sent, followed by new requests, which shows that the freed tag is the one reused.
- A response and a request are sent in the same cycle, including a request for the line being retired, which isolates the rule that an entry cannot be reused or bypassed in the cycle it is freed.
- A second response to an already retired tag exercises the sticky error and confirms the table is left unchanged.

A long stretch of random traffic over a small set of lines then mixes all of these cases. Every output is compared each cycle with a behavioural model.

// File: rtl/rt_pkg.sv
package rt_pkg;
    typedef enum logic {
        ENT_FREE = 1'b0,
        ENT_BUSY = 1'b1
    } ent_state_t;

    typedef enum logic {
        ERR_CLEAN = 1'b0,
        ERR_SEEN  = 1'b1
    } err_state_t;
endpackage

// File: rtl/rt_entry.sv
module rt_entry
    import rt_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int PID_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              retire,
    input  logic [LINE_W-1:0] line_in,
    input  logic [PID_W-1:0]  pid_in,
    input  logic              cmd_in,
    output logic              busy,
    output logic [LINE_W-1:0] line_q,
    output logic [PID_W-1:0]  pid_q,
    output logic              cmd_q
);
    ent_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (alloc)  state_d = ENT_BUSY;
            ENT_BUSY: if (retire) state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            pid_q  <= '0;
            cmd_q  <= 1'b0;
        end else if (state_q == ENT_FREE && alloc) begin
            line_q <= line_in;
            pid_q  <= pid_in;
            cmd_q  <= cmd_in;
        end
    end

    assign busy = (state_q == ENT_BUSY);
endmodule

// File: rtl/rt_pick.sv
module rt_pick #(
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 26,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             busy,
    input  logic [ENTRIES-1:0][LINE_W-1:0] lines,
    input  logic [LINE_W-1:0]              probe_line,
    output logic                           conflict,
    output logic                           any_free,
    output logic [TAG_W-1:0]               free_idx
);
    always_comb begin
        conflict = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (busy[i] && lines[i] == probe_line) conflict = 1'b1;
        end
    end

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                free_idx = TAG_W'(i);
            end
        end
    end
endmodule

// File: rtl/rt_table.sv
module rt_table
    import rt_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 26,
    parameter int PID_W   = 2,
    localparam int TAG_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LINE_W-1:0] req_line,
    input  logic [PID_W-1:0]  req_pid,
    input  logic              req_cmd,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    output logic              req_ack,
    output logic              req_nack,
    output logic [TAG_W-1:0]  req_tag,
    output logic              tbl_full,
    output logic [LINE_W-1:0] rsp_line,
    output logic [PID_W-1:0]  rsp_pid,
    output logic              rsp_cmd,
    output logic              proto_err
);
    logic [ENTRIES-1:0]             busy;
    logic [ENTRIES-1:0]             alloc_vec;
    logic [ENTRIES-1:0]             retire_vec;
    logic [ENTRIES-1:0][LINE_W-1:0] lines;
    logic [ENTRIES-1:0][PID_W-1:0]  pids;
    logic [ENTRIES-1:0]             cmds;
    logic                           conflict, any_free;
    logic [TAG_W-1:0]               free_idx;
    logic                           rsp_ok, rsp_bad, accept;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
            rt_entry #(.LINE_W(LINE_W), .PID_W(PID_W)) ent_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .alloc   (alloc_vec[g]),
                .retire  (retire_vec[g]),
                .line_in (req_line),
                .pid_in  (req_pid),
                .cmd_in  (req_cmd),
                .busy    (busy[g]),
                .line_q  (lines[g]),
                .pid_q   (pids[g]),
                .cmd_q   (cmds[g])
            );
        end
    endgenerate

    rt_pick #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) pick_i (
        .busy       (busy),
        .lines      (lines),
        .probe_line (req_line),
        .conflict   (conflict),
        .any_free   (any_free),
        .free_idx   (free_idx)
    );

    // Decisions use the table as it stands this cycle, so an entry
    // retired now is neither reusable nor bypassed until next cycle.
    always_comb begin
        rsp_ok     = rsp_valid && busy[rsp_tag];
        rsp_bad    = rsp_valid && !busy[rsp_tag];
        accept     = req_valid && !conflict && any_free;
        retire_vec = '0;
        alloc_vec  = '0;
        if (rsp_ok) retire_vec[rsp_tag] = 1'b1;
        if (accept) alloc_vec[free_idx] = 1'b1;
    end

    always_comb begin
        req_ack  = accept;
        req_nack = req_valid && !accept;
        req_tag  = accept ? free_idx : '0;
        tbl_full = &busy;
        rsp_line = rsp_ok ? lines[rsp_tag] : '0;
        rsp_pid  = rsp_ok ? pids[rsp_tag]  : '0;
        rsp_cmd  = rsp_ok ? cmds[rsp_tag]  : 1'b0;
    end

    err_state_t err_q, err_d;

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= ERR_CLEAN;
        else        err_q <= err_d;
    end

    always_comb begin
        err_d = err_q;
        unique case (err_q)
            ERR_CLEAN: if (rsp_bad) err_d = ERR_SEEN;
            ERR_SEEN:  err_d = ERR_SEEN;
        endcase
    end

    assign proto_err = (err_q == ERR_SEEN);
endmodule

// File: rtl/rt_chk.sv
module rt_chk #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ack,
    input logic               req_nack,
    input logic [TAG_W-1:0]   req_tag,
    input logic               rsp_valid,
    input logic [TAG_W-1:0]   rsp_tag,
    input logic               tbl_full,
    input logic               proto_err,
    input logic [ENTRIES-1:0] busy
);
    a_r2_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_ack ^ req_nack));

    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!req_ack && !req_nack));

    a_r2_alloc_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> busy[$past(req_tag)]);

    a_r4_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_full && req_valid) |-> req_nack);

    a_r5_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && busy[rsp_tag]) |=> !busy[$past(rsp_tag)]);

    a_r6_no_same_cycle_reuse: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && busy[rsp_tag] && req_ack) |-> (req_tag != rsp_tag));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);
endmodule

bind rt_table rt_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) chk_i (.*);

// File: tb/rt_table_tb.sv
module rt_table_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 8;
    localparam int LW  = 26;
    localparam int PW  = 2;
    localparam int TW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [LW-1:0] req_line = '0;
    logic [PW-1:0] req_pid = '0;
    logic          req_cmd = 1'b0;
    logic          rsp_valid = 1'b0;
    logic [TW-1:0] rsp_tag = '0;
    logic          req_ack, req_nack, tbl_full, rsp_cmd, proto_err;
    logic [TW-1:0] req_tag;
    logic [LW-1:0] rsp_line;
    logic [PW-1:0] rsp_pid;

    int errors = 0;
    int checks = 0;

    // behavioural reference
    bit m_valid [N];
    int m_line  [N];
    int m_pid   [N];
    int m_cmd   [N];
    bit m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    rt_table #(.ENTRIES(N), .LINE_W(LW), .PID_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_line(req_line), .req_pid(req_pid), .req_cmd(req_cmd),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .req_ack(req_ack), .req_nack(req_nack), .req_tag(req_tag), .tbl_full(tbl_full),
        .rsp_line(rsp_line), .rsp_pid(rsp_pid), .rsp_cmd(rsp_cmd), .proto_err(proto_err)
    );

    task automatic chk(string r, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", r, what, act, exp, $time);
        end
    endtask

    task automatic cyc(string lbl, bit rv, int ln, int pid, bit cmd, bit sv, int tg);
        bit conf, full, ok, acc;
        int fi;
        string r;
        @(negedge clk);
        req_valid = rv; req_line = LW'(ln); req_pid = PW'(pid); req_cmd = cmd;
        rsp_valid = sv; rsp_tag = TW'(tg);
        #1;
        conf = 0; full = 1; fi = -1;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_valid[i] && m_line[i] == ln) conf = 1;
            if (!m_valid[i]) begin full = 0; fi = i; end
        end
        acc = rv && !conf && !full;
        ok  = sv && m_valid[tg];
        r = (lbl != "") ? lbl : (conf ? "R3" : (full ? "R4" : "R2"));
        chk(r, "req_ack", int'(req_ack), int'(acc));
        chk(r, "req_nack", int'(req_nack), int'(rv && !acc));
        chk(r, "req_tag", int'(req_tag), acc ? fi : 0);
        chk("R4", "tbl_full", int'(tbl_full), int'(full));
        chk("R7", "proto_err", int'(proto_err), int'(m_err));
        chk("R8", "rsp_line", int'(rsp_line), ok ? m_line[tg] : 0);
        chk("R8", "rsp_pid", int'(rsp_pid), ok ? m_pid[tg] : 0);
        chk("R8", "rsp_cmd", int'(rsp_cmd), ok ? m_cmd[tg] : 0);
        @(posedge clk);
        if (ok) m_valid[tg] = 0;
        else if (sv) m_err = 1;
        if (acc) begin
            m_valid[fi] = 1; m_line[fi] = ln; m_pid[fi] = pid; m_cmd[fi] = cmd;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1", "tbl_full", int'(tbl_full), 0);
        chk("R1", "proto_err", int'(proto_err), 0);
        chk("R1", "req_ack", int'(req_ack), 0);
        chk("R1", "req_nack", int'(req_nack), 0);
        cyc("R1", 0, 0, 0, 0, 0, 0);

        // R2: lowest free tags 0,1,2
        cyc("R2", 1, 'h100, 1, 0, 0, 0);
        cyc("R2", 1, 'h200, 2, 1, 0, 0);
        cyc("R2", 1, 'h300, 3, 0, 0, 0);
        // R3: reissue pending line
        cyc("R3", 1, 'h200, 0, 0, 0, 0);
        // fill to capacity, then R4
        for (int k = 0; k < 5; k++) cyc("R2", 1, 'h400 + k, k % 4, k % 2, 0, 0);
        cyc("R4", 1, 'h999, 0, 0, 0, 0);
        // R5: out-of-order retire of tag 5 (R8 fields), then reuse
        cyc("R5", 0, 0, 0, 0, 1, 5);
        cyc("R5", 1, 'h555, 2, 1, 0, 0);
        // R6: retire 2 while requesting; full so refused, next cycle gets 2
        cyc("R6", 1, 'h666, 1, 0, 1, 2);
        cyc("R6", 1, 'h666, 1, 0, 0, 0);
        // R6: request the line being retired (tag 0) in the same cycle
        cyc("R6", 1, 'h100, 3, 1, 1, 0);
        cyc("R6", 1, 'h100, 3, 1, 0, 0);
        // R7: second response to a retired tag
        cyc("R5", 0, 0, 0, 0, 1, 3);
        cyc("R7", 0, 0, 0, 0, 1, 3);
        cyc("R7", 1, 'h777, 0, 0, 0, 0);
        cyc("R7", 0, 0, 0, 0, 0, 0);
        // drain, then random traffic over few lines
        for (int t = 0; t < N; t++) cyc("R5", 0, 0, 0, 0, 1, t);
        for (int n = 0; n < 2000; n++) begin
            cyc("", $urandom_range(0, 1), $urandom_range(0, 11), $urandom_range(0, 3),
                $urandom_range(0, 1), ($urandom_range(0, 2) == 0), $urandom_range(0, N - 1));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule